// File: doc/BRIEF.md
# Serial Flash Streaming Read Slave

This block is the device side of a serial flash read. A host selects the device by pulling its active-low select low, clocks in an 8-bit opcode and then a 24-bit byte address. The clock idles low, and the device samples input bits on the clock's rising edge. When the opcode is the read code, the block fetches bytes from a synchronous memory array and shifts them out, changing its serial output on the clock's falling edges. After each byte it moves to the next address. A single command can therefore stream the whole array for as long as the host keeps clocking. The command ends when the select returns high.

The serial pins are oversampled by the block's own system clock. They pass through a short synchronizer and an edge detector, so the whole block is one synchronous domain together with the memory port. The memory port issues a one-cycle read strobe with an address and expects the byte on the following clock. When the array is busy with an erase, program or write cycle, an incoming read is refused. It then produces no output and no memory traffic. The serial output is presented as a data bit plus an output enable for an external pad buffer. An enable of 0 means high impedance.

The serial clock high and low phases must each last at least 4 system clock cycles.

Top module: `spi_read_engine`

## Requirements
- R1: A command is the opcode 0x03 followed by a 24-bit address, both sent most significant bit first. Each bit is sampled on a rising edge of `sclk` while `cs_n` is low. The returned data starts at the byte stored at that address.
- R2: Data bytes leave most significant bit first. `so_o` changes only after falling edges of `sclk`. The first data bit is valid after the first falling edge that follows the 24th address bit. `so_o` holds steady through each high phase of `sclk`.
- R3: After each byte, the read address advances by one, so consecutive bytes come from consecutive addresses with no length limit.
- R4: The read address is 16 bits wide. After 0xFFFF it wraps to 0x0000.
- R5: If `busy` is 1 at any rising edge of `sclk` during the opcode or address bits, the command is refused. For the rest of that selection, `so_oe` stays 0 and `mem_rd_en` is never asserted.
- R6: Any opcode other than 0x03 is refused in the same way: no output enable and no memory reads until `cs_n` rises.
- R7: `so_oe` is 0 in two cases: while `cs_n` is high, and during the opcode and address bits.
- R8: Raising `cs_n` at any point aborts the command and clears the bit count. The next selection decodes a fresh opcode.
- R9: After reset, `so_oe` and `mem_rd_en` are 0.
- R10: Address bits 23 to 16 have no effect on which bytes are returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles low |
| cs_n | input | 1 | Active-low device select |
| si | input | 1 | Serial data from host |
| so_o | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so_o`; 0 means high impedance |
| busy | input | 1 | Array busy with erase, program or write |
| mem_rd_en | output | 1 | One-cycle memory read strobe |
| mem_addr | output | AW (16) | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid the cycle after the strobe |

## Verification
The hardest case to reach is a refusal that depends on `busy` being seen during the address phase alone. The bench raises `busy` for exactly one serial clock period in the middle of the address bits and keeps it low around that period. It then clocks on well past where data would begin, and checks that the enable never rose and that the memory strobe counter did not move. Wrap-around needs a start address two bytes below the top of the array, with junk in the upper address byte. Aborts are placed both mid-address and mid-byte, each followed by a clean read.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int OPC_BITS = 8;
    localparam int ADR_BITS = 24;
    localparam logic [OPC_BITS-1:0] OPC_READ = 8'h03;

    typedef enum logic [1:0] {
        PH_OPC = 2'd0,
        PH_ADR = 2'd1,
        PH_DAT = 2'd2,
        PH_REJ = 2'd3
    } phase_e;

    // synchronized serial pin view plus edge events
    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic si;
    } pins_t;

    function automatic logic opc_is_read(input logic [OPC_BITS-1:0] opc);
        return opc == OPC_READ;
    endfunction

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync
    import spi_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  si,
    output pins_t pins
);
    localparam int LAST = STAGES - 1;

    // [2]=sclk [1]=select (active high) [0]=si
    logic [STAGES-1:0][2:0] pipe;
    logic                   sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '0;
            sclk_d <= 1'b0;
        end else begin
            pipe[0] <= {sclk, ~cs_n, si};
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
            sclk_d <= pipe[LAST][2];
        end
    end

    always_comb begin
        pins.rise = pipe[LAST][2] & ~sclk_d;
        pins.fall = ~pipe[LAST][2] & sclk_d;
        pins.sel  = pipe[LAST][1];
        pins.si   = pipe[LAST][0];
    end

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pins_t         pins,
    input  logic          busy,
    output phase_e        phase,
    output logic          start,
    output logic [AW-1:0] start_addr
);
    localparam int CW = $clog2(ADR_BITS);
    localparam logic [CW-1:0] OPC_LAST = CW'(OPC_BITS - 1);
    localparam logic [CW-1:0] ADR_LAST = CW'(ADR_BITS - 1);

    logic [AW-2:0] sr;
    logic [CW-1:0] cnt;
    logic          bad;

    always_ff @(posedge clk) begin
        if (rst || !pins.sel) begin
            phase      <= PH_OPC;
            cnt        <= '0;
            bad        <= 1'b0;
            sr         <= '0;
            start      <= 1'b0;
            if (rst) start_addr <= '0;
        end else begin
            start <= 1'b0;
            if (pins.rise) begin
                unique case (phase)
                    PH_OPC: begin
                        sr  <= {sr[AW-3:0], pins.si};
                        cnt <= cnt + 1'b1;
                        if (busy) bad <= 1'b1;
                        if (cnt == OPC_LAST) begin
                            cnt   <= '0;
                            phase <= (opc_is_read({sr[OPC_BITS-2:0], pins.si}) && !busy && !bad)
                                     ? PH_ADR : PH_REJ;
                        end
                    end
                    PH_ADR: begin
                        sr  <= {sr[AW-3:0], pins.si};
                        cnt <= cnt + 1'b1;
                        if (busy) bad <= 1'b1;
                        if (cnt == ADR_LAST) begin
                            cnt        <= '0;
                            phase      <= (busy || bad) ? PH_REJ : PH_DAT;
                            start      <= !(busy || bad);
                            start_addr <= {sr, pins.si};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.sel |=> (phase == PH_OPC && !start));

    // R5
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (pins.sel && pins.rise && busy && (phase == PH_OPC || phase == PH_ADR))
        |=> (phase != PH_DAT && !start));

    // R1
    start_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> ($past(phase) == PH_ADR && phase == PH_DAT));

endmodule

// File: rtl/spi_rd_tx.sv
module spi_rd_tx
    import spi_rd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pins_t         pins,
    input  phase_e        phase,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    mem_rdata,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    output logic          so_o,
    output logic          so_oe
);
    logic [7:0] nxt;
    logic [7:0] sh;
    logic [2:0] dbit;
    logic       rd_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt       <= '0;
            sh        <= '0;
            dbit      <= '0;
            rd_vld    <= 1'b0;
            mem_rd_en <= 1'b0;
            mem_addr  <= '0;
            so_o      <= 1'b0;
            so_oe     <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            rd_vld    <= mem_rd_en;
            if (rd_vld) nxt <= mem_rdata;
            if (!pins.sel) begin
                dbit  <= '0;
                so_oe <= 1'b0;
                so_o  <= 1'b0;
            end else if (start) begin
                mem_addr  <= start_addr;
                mem_rd_en <= 1'b1;
                dbit      <= '0;
            end else if (phase == PH_DAT && pins.fall) begin
                so_oe <= 1'b1;
                dbit  <= dbit + 1'b1;
                if (dbit == 3'd0) begin
                    so_o      <= nxt[7];
                    sh        <= {nxt[6:0], 1'b0};
                    mem_addr  <= mem_addr + AW'(1);
                    mem_rd_en <= 1'b1;
                end else begin
                    so_o <= sh[7];
                    sh   <= {sh[6:0], 1'b0};
                end
            end
        end
    end

    // R7
    oe_off_unselected_chk: assert property (@(posedge clk) disable iff (rst)
        !pins.sel |=> !so_oe);

    // R2
    so_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (so_oe && !$stable(so_o)) |-> $past(pins.fall));

    // R3
    rd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R6
    oe_only_data_chk: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> phase == PH_DAT);

endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine
    import spi_rd_pkg::*;
#(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          si,
    output logic          so_o,
    output logic          so_oe,
    input  logic          busy,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata
);
    pins_t         pins;
    phase_e        phase;
    logic          start;
    logic [AW-1:0] start_addr;

    spi_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .si   (si),
        .pins (pins)
    );

    spi_rd_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pins       (pins),
        .busy       (busy),
        .phase      (phase),
        .start      (start),
        .start_addr (start_addr)
    );

    spi_rd_tx #(.AW(AW)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .pins       (pins),
        .phase      (phase),
        .start      (start),
        .start_addr (start_addr),
        .mem_rdata  (mem_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .so_o       (so_o),
        .so_oe      (so_oe)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!so_oe && !mem_rd_en));

endmodule

// File: tb/spi_read_engine_bench.sv
`timescale 1ns/1ps
module spi_read_engine_bench;
    localparam int AW = 16;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          cs_n = 1'b1;
    logic          si = 1'b0;
    logic          busy = 1'b0;
    logic          so_o, so_oe, mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];

    always #2.5 clk = ~clk;

    spi_read_engine #(.AW(AW)) u_spi_read_engine (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .si(si),
        .so_o(so_o), .so_oe(so_oe), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pat(mem_addr);
        if (!rst && mem_rd_en) rd_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic v, output logic lo, output logic hi, output logic oe);
        si = v;
        tick(H);
        lo = so_o;
        oe = so_oe;
        sclk = 1'b1;
        tick(H);
        hi = so_o;
        sclk = 1'b0;
    endtask

    // busy_bit: header bit index during which busy is high, -1 for none
    task automatic send_hdr(input logic [7:0] opc, input logic [23:0] adr,
                            input int busy_bit, output logic any_oe);
        logic [31:0] w;
        logic lo, hi, oe;
        w = {opc, adr};
        any_oe = 1'b0;
        cs_n = 1'b0;
        tick(H);
        for (int i = 0; i < 32; i++) begin
            busy = (i == busy_bit);
            bit_cycle(w[31-i], lo, hi, oe);
            any_oe |= oe;
        end
        busy = 1'b0;
    endtask

    task automatic end_cmd(input string req);
        cs_n = 1'b1;
        tick(2 * H);
        check(so_oe == 1'b0, req, "so_oe after deselect", so_oe, 0);
    endtask

    task automatic do_read(input logic [23:0] adr, input int n, input string req);
        logic oe_hdr, lo, hi, oe;
        logic [7:0] blo, bhi;
        bit steady, all_oe;
        steady = 1'b1;
        all_oe = 1'b1;
        cur_req = req;
        send_hdr(8'h03, adr, -1, oe_hdr);
        check(!oe_hdr, "R7", "so_oe during header", oe_hdr, 0);
        for (int b = 0; b < n; b++) begin
            exp_q.push_back(pat(adr[15:0] + 16'(b)));
            for (int k = 0; k < 8; k++) begin
                bit_cycle(1'b0, lo, hi, oe);
                blo = {blo[6:0], lo};
                bhi = {bhi[6:0], hi};
                all_oe &= oe;
            end
            act_q.push_back(blo);
            if (bhi != blo) steady = 1'b0;
        end
        check(all_oe, "R2", "so_oe from first data bit", all_oe, 1);
        check(steady, "R2", "so_o steady in high phase", steady, 1);
        end_cmd("R7");
    endtask

    task automatic do_reject(input logic [7:0] opc, input int busy_bit, input string req);
        logic oe_hdr, lo, hi, oe;
        logic any;
        int rd0;
        rd0 = rd_cnt;
        send_hdr(opc, 24'h000040, busy_bit, oe_hdr);
        any = oe_hdr;
        for (int k = 0; k < 16; k++) begin
            bit_cycle(1'b0, lo, hi, oe);
            any |= oe;
        end
        check(!any, req, "so_oe in refused command", any, 0);
        check(rd_cnt == rd0, req, "memory reads in refused command", rd_cnt - rd0, 0);
        end_cmd(req);
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0] a, e;
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                a = act_q.pop_front();
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                check(a === e, cur_req, "data byte", a, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic dummy, lo, hi, oe;
        tick(5);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        check(so_oe == 1'b0, "R9", "so_oe after reset", so_oe, 0);
        check(mem_rd_en == 1'b0, "R9", "mem_rd_en after reset", mem_rd_en, 0);
        check(rd_cnt == 0, "R9", "no reads after reset", rd_cnt, 0);

        // R1 basic read
        do_read(24'h001234, 5, "R1");
        // R3 long stream
        do_read(24'h000100, 40, "R3");
        // R4 wrap, R10 upper bits ignored
        do_read(24'hABFFFE, 4, "R4");
        do_read(24'h7F1234, 3, "R10");

        // R5 busy during opcode, then only during one address bit
        do_reject(8'h03, 3, "R5");
        do_reject(8'h03, 20, "R5");
        // R6 foreign opcodes
        do_reject(8'h0B, -1, "R6");
        do_reject(8'h83, -1, "R6");

        // R8 abort mid-address, then clean read
        cs_n = 1'b0;
        tick(H);
        for (int i = 0; i < 14; i++) bit_cycle(i == 6 || i == 7, lo, hi, oe);
        end_cmd("R8");
        do_read(24'h00ABCD, 2, "R8");

        // R8 abort mid-byte, then clean read
        send_hdr(8'h03, 24'h000500, -1, dummy);
        for (int k = 0; k < 3; k++) bit_cycle(1'b0, lo, hi, oe);
        end_cmd("R8");
        do_read(24'h000020, 3, "R8");

        tick(4);
        check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule